// File: doc/BRIEF.md
# Ultra DMA Write Burst Sequencer

This block is the host side of an ATA Ultra DMA data-out burst. When software-side logic pulses `start` while the device requests service, the sequencer acknowledges the device, drops STOP, and drives 16-bit words onto the data bus, one per edge of the host strobe. Words arrive from an upstream valid/ready stream. The burst ends in one of two ways: when the programmed word count is used up, or when the device withdraws its request. In both cases the engine raises STOP, drives a CRC-16 word, returns the strobe high and releases the acknowledge.

Every protocol interval is a clock count taken from its own configuration input. These intervals are the acknowledge envelope, the acknowledge setup and hold, the data setup before an edge, the data hold after an edge, the STOP delay and the interlock. The setup and hold counts together set the strobe half-period. All device-side signals are shown here in active-high logical form, so pad polarity and pad delays sit outside the block.

Stream rules: a word moves only on a clock where `s_valid` and `s_ready` are both high. `s_ready` is high only in a clock where the sequencer is ready to place the next word on the bus. While `s_valid` is low, the bus holds the previous word and no strobe edge is made. The source may raise `s_valid` at any time and must hold `s_data` steady until the word is taken.

Top module: `udma_out_engine`

## Requirements
- R1: After reset, `host_ack`=0, `host_stop`=1, `host_strobe`=1, `bus_oe`=0 and `s_ready`=0.
- R2: A `start` pulse seen in idle while `dev_req`=1 raises `host_ack` on the next clock. `host_stop` falls exactly ENV clocks after `host_ack` rises, and `host_stop` is never low without `host_ack`.
- R3: The first word is driven (`bus_oe` rises) exactly ACK clocks after `host_stop` falls, provided the stream is valid. `host_strobe` never changes unless `host_ack` is high in that clock and the one before.
- R4: The first strobe edge comes exactly SETUP clocks after the first word is driven, and `bus_out` is unchanged in every clock in which the strobe toggles.
- R5: When the stream and device keep up, consecutive data strobe edges are exactly SETUP+HOLD clocks apart.
- R6: Exactly `xfer_words` words are sent, in stream order, one per strobe edge. A word is consumed only on `s_valid && s_ready`, and a late `s_valid` delays edges without losing or repeating a word.
- R7: While `dev_ready` is low, no new word is loaded, and at most three strobe edges occur. Strobing resumes after `dev_ready` is seen high.
- R8: `host_stop` rises exactly HOLD+STOPDLY clocks after the last data strobe edge.
- R9: The CRC word appears on `bus_out` exactly ILOCK clocks after `host_stop` rises, with `host_ack` still high.
- R10: The CRC is CRC-16 with polynomial 0x1021. It is seeded to 0x4ABA at burst start and updated once per sent word. Each word is processed MSB first, and the feedback bit is crc[15] XOR the data bit.
- R11: `host_strobe` is 1 exactly SETUP clocks after the CRC is driven. The CRC and `host_ack` then stay for ACK more clocks, after which `host_ack` and `bus_oe` fall together with a one-clock `done` pulse.
- R12: Any configuration count programmed as 0 behaves as 1.
- R13: If `dev_req` is low when the next word would be loaded, the burst ends early through the R8-R11 sequence, with the CRC covering only the words actually sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_setup | input | CW | Data setup count before each strobe edge |
| cfg_hold | input | CW | Data hold count after each strobe edge |
| cfg_ack | input | CW | Acknowledge setup/hold count |
| cfg_env | input | CW | Acknowledge-to-STOP envelope count |
| cfg_ilock | input | CW | Interlock count after STOP rises |
| cfg_stop_dly | input | CW | Delay from hold end to STOP assertion |
| start | input | 1 | Begin a burst (one-clock pulse) |
| xfer_words | input | LW | Words to send in the burst |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted this clock |
| s_data | input | DW | Stream word |
| dev_req | input | 1 | Device DMA request |
| dev_ready | input | 1 | Device ready to receive |
| host_ack | output | 1 | DMA acknowledge to device |
| host_stop | output | 1 | STOP line |
| host_strobe | output | 1 | Host data strobe |
| bus_out | output | DW | Data bus value |
| bus_oe | output | 1 | Data bus drive enable |
| done | output | 1 | One-clock pulse at burst end |

## Verification
A phase counter or state that is off by one shows at the ports within one burst. The distance between `host_ack`, `host_stop`, `bus_oe` and the strobe edges then differs from its programmed count, and the bench measures each distance to the exact clock. A wrong word pointer or a CRC register updated at the wrong time shows up as a wrong word at an edge or a wrong CRC value. The CRC value appears a fixed ILOCK clocks after STOP rises. Early-termination and pause faults show as a wrong word count or as strobe edges while the device is not ready.

// File: rtl/udma_out_pkg.sv
package udma_out_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ENV, ST_ACK, ST_SETUP, ST_HOLD,
    ST_WAIT, ST_SS, ST_MLI, ST_CRCS, ST_CRCH
  } phase_t;

  localparam int NUM_CNT = 6;
  localparam int CI_SETUP = 0;
  localparam int CI_HOLD  = 1;
  localparam int CI_ACK   = 2;
  localparam int CI_ENV   = 3;
  localparam int CI_ILOCK = 4;
  localparam int CI_STOP  = 5;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'h4ABA;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 15; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/udma_min1.sv
module udma_min1 #(
  parameter int W = 8
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] eff
);
  assign eff = (raw == '0) ? W'(1) : raw;
endmodule

// File: rtl/udma_phase_timer.sv
module udma_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len - W'(1);
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);

  AST_TIMER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> (cnt == '0)); // R12
endmodule

// File: rtl/udma_crc16.sv
module udma_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [15:0] word,
  output logic [15:0] crc
);
  import udma_out_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)    crc <= CRC_SEED;
    else if (init) crc <= CRC_SEED;
    else if (upd)  crc <= crc_step(crc, word);
  end

  AST_CRC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !upd) |=> $stable(crc)); // R10
endmodule

// File: rtl/udma_out_engine.sv
module udma_out_engine
  import udma_out_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_hold,
  input  logic [CW-1:0] cfg_ack,
  input  logic [CW-1:0] cfg_env,
  input  logic [CW-1:0] cfg_ilock,
  input  logic [CW-1:0] cfg_stop_dly,
  input  logic          start,
  input  logic [LW-1:0] xfer_words,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          dev_req,
  input  logic          dev_ready,
  output logic          host_ack,
  output logic          host_stop,
  output logic          host_strobe,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          done
);
  logic [NUM_CNT-1:0][CW-1:0] raw_cnt, eff_cnt;
  assign raw_cnt[CI_SETUP] = cfg_setup;
  assign raw_cnt[CI_HOLD]  = cfg_hold;
  assign raw_cnt[CI_ACK]   = cfg_ack;
  assign raw_cnt[CI_ENV]   = cfg_env;
  assign raw_cnt[CI_ILOCK] = cfg_ilock;
  assign raw_cnt[CI_STOP]  = cfg_stop_dly;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_clamp
    udma_min1 #(.W(CW)) u_clamp (.raw(raw_cnt[g]), .eff(eff_cnt[g]));
  end

  phase_t        st, st_n;
  logic [LW-1:0] remain;
  logic          t_load, t_exp;
  logic [CW-1:0] t_len;
  logic          dec, finish, do_take;
  logic          begin_b, stop_lo, stop_hi, toggle, load_crc, final_stb, release_b;
  logic [15:0]   crc_q;

  udma_phase_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .expired(t_exp));

  udma_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .init(begin_b), .upd(do_take),
    .word(16'(s_data)), .crc(crc_q));

  assign dec     = (((st == ST_ACK) || (st == ST_HOLD)) && t_exp) || (st == ST_WAIT);
  assign finish  = (remain == '0) || !dev_req;
  assign s_ready = dec && !finish && dev_ready;
  assign do_take = s_ready && s_valid;

  always_comb begin
    st_n = st; t_load = 1'b0; t_len = eff_cnt[CI_SETUP];
    begin_b = 1'b0; stop_lo = 1'b0; stop_hi = 1'b0; toggle = 1'b0;
    load_crc = 1'b0; final_stb = 1'b0; release_b = 1'b0;
    case (st)
      ST_IDLE: if (start && dev_req) begin
        st_n = ST_ENV; t_load = 1'b1; t_len = eff_cnt[CI_ENV]; begin_b = 1'b1;
      end
      ST_ENV: if (t_exp) begin
        st_n = ST_ACK; t_load = 1'b1; t_len = eff_cnt[CI_ACK]; stop_lo = 1'b1;
      end
      ST_ACK, ST_HOLD, ST_WAIT: if (dec) begin
        if (finish) begin
          st_n = ST_SS; t_load = 1'b1; t_len = eff_cnt[CI_STOP];
        end else if (do_take) begin
          st_n = ST_SETUP; t_load = 1'b1; t_len = eff_cnt[CI_SETUP];
        end else begin
          st_n = ST_WAIT;
        end
      end
      ST_SETUP: if (t_exp) begin
        st_n = ST_HOLD; t_load = 1'b1; t_len = eff_cnt[CI_HOLD]; toggle = 1'b1;
      end
      ST_SS: if (t_exp) begin
        st_n = ST_MLI; t_load = 1'b1; t_len = eff_cnt[CI_ILOCK]; stop_hi = 1'b1;
      end
      ST_MLI: if (t_exp) begin
        st_n = ST_CRCS; t_load = 1'b1; t_len = eff_cnt[CI_SETUP]; load_crc = 1'b1;
      end
      ST_CRCS: if (t_exp) begin
        st_n = ST_CRCH; t_load = 1'b1; t_len = eff_cnt[CI_ACK]; final_stb = 1'b1;
      end
      ST_CRCH: if (t_exp) begin
        st_n = ST_IDLE; release_b = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; remain <= '0; host_ack <= 1'b0; host_stop <= 1'b1;
      host_strobe <= 1'b1; bus_out <= '0; bus_oe <= 1'b0; done <= 1'b0;
    end else begin
      st   <= st_n;
      done <= release_b;
      if (begin_b) begin
        host_ack <= 1'b1; host_stop <= 1'b1; host_strobe <= 1'b1; remain <= xfer_words;
      end
      if (stop_lo) host_stop <= 1'b0;
      if (stop_hi) host_stop <= 1'b1;
      if (do_take) begin
        bus_out <= s_data; bus_oe <= 1'b1; remain <= remain - LW'(1);
      end
      if (toggle)    host_strobe <= ~host_strobe;
      if (final_stb) host_strobe <= 1'b1;
      if (load_crc) begin
        bus_out <= DW'(crc_q); bus_oe <= 1'b1;
      end
      if (release_b) begin
        host_ack <= 1'b0; bus_oe <= 1'b0; bus_out <= '0;
      end
    end
  end

  AST_STROBE_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (host_strobe != $past(host_strobe)) |-> (host_ack && $past(host_ack))); // R3
  AST_DATA_HELD_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_strobe != $past(host_strobe)) |-> (bus_out == $past(bus_out))); // R4
  AST_STOP_LOW_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !host_stop |-> host_ack); // R2
  AST_BUS_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> host_ack); // R11
  AST_NO_TAKE_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> $stable(bus_out)); // R6
endmodule

// File: tb/sim_udma_out_engine.sv
`timescale 1ns/1ps
module sim_udma_out_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] c_dvs = 8'd1, c_dvh = 8'd1, c_ack = 8'd1, c_env = 8'd1, c_mli = 8'd1, c_ss = 8'd1;
  logic start = 1'b0;
  logic [15:0] xfer = '0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [15:0] s_data = '0;
  logic dev_req = 1'b0, dev_ready = 1'b1;
  logic host_ack, host_stop, host_strobe, bus_oe, done;
  logic [15:0] bus_out;

  udma_out_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_setup(c_dvs), .cfg_hold(c_dvh), .cfg_ack(c_ack),
    .cfg_env(c_env), .cfg_ilock(c_mli), .cfg_stop_dly(c_ss), .start(start),
    .xfer_words(xfer), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .dev_req(dev_req), .dev_ready(dev_ready), .host_ack(host_ack), .host_stop(host_stop),
    .host_strobe(host_strobe), .bus_out(bus_out), .bus_oe(bus_oe), .done(done));

  int total = 0, fails = 0;

  function automatic logic [15:0] pat(input int i);
    return 16'(i) * 16'h2F1B + 16'h5A0F;
  endfunction

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    for (int i = 15; i >= 0; i--) begin
      logic fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  function automatic int eff(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // stream source
  int src_idx = 0;
  bit src_on = 1'b0, gap_en = 1'b0;
  logic fire = 1'b0;
  int cyc = 0;
  always @(posedge clk) fire <= s_valid && s_ready;
  always @(negedge clk) begin
    if (fire) src_idx++;
    s_data  = pat(src_idx);
    s_valid = src_on && !(gap_en && ((cyc % 5) < 3));
  end

  // port monitor
  logic [15:0] dd_h [4096];
  logic hs_h [4096];
  bit mon = 1'b0, done_seen = 1'b0;
  int t_dr, t_df, t_sf, t_sr, t_oe, n_e, pause_edges;
  int t_e [64];
  logic [15:0] w_e [64];
  logic p_ack = 1'b0, p_stop = 1'b1, p_hs = 1'b1, p_oe = 1'b0;

  always @(negedge clk) begin
    cyc++;
    dd_h[cyc % 4096] = bus_out;
    hs_h[cyc % 4096] = host_strobe;
    if (mon) begin
      if (host_ack && !p_ack) t_dr = cyc;
      if (!host_ack && p_ack) t_df = cyc;
      if (!host_stop && p_stop) t_sf = cyc;
      if (host_stop && !p_stop) t_sr = cyc;
      if (bus_oe && !p_oe && t_oe < 0) t_oe = cyc;
      if (host_strobe != p_hs && !host_stop && n_e < 64) begin
        t_e[n_e] = cyc; w_e[n_e] = bus_out; n_e++;
        if (!dev_ready) pause_edges++;
      end
      if (done) done_seen = 1'b1;
    end
    p_ack = host_ack; p_stop = host_stop; p_hs = host_strobe; p_oe = bus_oe;
  end

  task automatic run_burst(input logic [7:0] dvs, dvh, ack, env, mli, ss,
                           input int nw, input bit gap, input bit pz, input int drop_after,
                           output int n_sent, output logic [15:0] crc_x);
    int pz_cnt = 0;
    int E_dvs = eff(dvs), E_dvh = eff(dvh), E_ack = eff(ack), E_env = eff(env);
    int E_mli = eff(mli), E_ss = eff(ss);
    int bad_sp = 0, bad_w = 0, tc;
    @(posedge clk);
    src_idx = 0; t_dr = -1; t_df = -1; t_sf = -1; t_sr = -1; t_oe = -1; n_e = 0;
    pause_edges = 0; done_seen = 1'b0;
    c_dvs = dvs; c_dvh = dvh; c_ack = ack; c_env = env; c_mli = mli; c_ss = ss;
    xfer = 16'(nw); gap_en = gap; src_on = 1'b1; dev_req = 1'b1; dev_ready = 1'b1; mon = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (pz && n_e >= 3 && pz_cnt < 40) begin dev_ready = 1'b0; pz_cnt++; end
      else dev_ready = 1'b1;
      if (drop_after > 0 && n_e >= drop_after) dev_req = 1'b0;
      if (done_seen) break;
    end
    repeat (2) @(negedge clk);
    mon = 1'b0; src_on = 1'b0; dev_ready = 1'b1;
    chk(done_seen, "R11", "watchdog: burst finished", int'(done_seen), 1);
    n_sent = n_e;
    crc_x = 16'h4ABA;
    for (int i = 0; i < n_e; i++) begin
      crc_x = crc_ref(crc_x, pat(i));
      if (w_e[i] != pat(i)) bad_w++;
      if (i > 0) begin
        if (!gap && !pz && (t_e[i] - t_e[i-1]) != E_dvs + E_dvh) bad_sp++;
        if ((t_e[i] - t_e[i-1]) < E_dvs + E_dvh) bad_sp++;
      end
    end
    chk(t_sf - t_dr == E_env, "R2", "ack to stop low", t_sf - t_dr, E_env);
    if (nw > 0 && !gap) begin
      chk(t_oe - t_sf == E_ack, "R3", "stop low to first word", t_oe - t_sf, E_ack);
    end
    if (n_e > 0) begin
      chk(t_e[0] - t_oe == E_dvs, "R4", "first word to first edge", t_e[0] - t_oe, E_dvs);
      chk(t_sr - t_e[n_e-1] == E_dvh + E_ss, "R8", "last edge to stop high",
          t_sr - t_e[n_e-1], E_dvh + E_ss);
    end
    chk(bad_sp == 0, "R5", "edge spacing errors", bad_sp, 0);
    chk(bad_w == 0, "R6", "word order errors", bad_w, 0);
    chk(src_idx == n_e, "R6", "stream words consumed vs edges", src_idx, n_e);
    tc = t_sr + E_mli;
    chk(dd_h[tc % 4096] == crc_x, "R9", "bus at interlock end", int'(dd_h[tc % 4096]), int'(crc_x));
    chk(hs_h[(tc + E_dvs) % 4096] == 1'b1, "R11", "final strobe high",
        int'(hs_h[(tc + E_dvs) % 4096]), 1);
    chk(t_df - (tc + E_dvs) == E_ack, "R11", "final strobe to ack release",
        t_df - (tc + E_dvs), E_ack);
    chk(dd_h[(t_df - 1) % 4096] == crc_x, "R10", "crc held until release",
        int'(dd_h[(t_df - 1) % 4096]), int'(crc_x));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(host_ack == 0 && host_stop == 1 && host_strobe == 1, "R1", "ack/stop/strobe reset",
        {host_ack, host_stop, host_strobe}, 3'b011);
    chk(bus_oe == 0 && s_ready == 0, "R1", "oe/ready reset", {bus_oe, s_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_basic;
    int n; logic [15:0] c;
    run_burst(8'd2, 8'd3, 8'd2, 8'd3, 8'd2, 8'd2, 8, 0, 0, 0, n, c);
    chk(n == 8, "R6", "basic word count", n, 8);
  endtask

  task automatic t_fast;
    int n; logic [15:0] c;
    run_burst(8'd1, 8'd1, 8'd1, 8'd1, 8'd4, 8'd5, 5, 0, 0, 0, n, c);
    chk(n == 5, "R6", "fast word count", n, 5);
  endtask

  task automatic t_zero_counts;
    int n; logic [15:0] c;
    run_burst(8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 4, 0, 0, 0, n, c);
    chk(n == 4, "R12", "zero counts act as one, word count", n, 4);
  endtask

  task automatic t_stream_gaps;
    int n; logic [15:0] c;
    run_burst(8'd2, 8'd1, 8'd3, 8'd2, 8'd3, 8'd1, 10, 1, 0, 0, n, c);
    chk(n == 10, "R6", "gapped stream word count", n, 10);
  endtask

  task automatic t_pause;
    int n; logic [15:0] c;
    run_burst(8'd2, 8'd2, 8'd2, 8'd2, 8'd2, 8'd2, 9, 0, 1, 0, n, c);
    chk(pause_edges <= 3, "R7", "edges while device not ready", pause_edges, 3);
    chk(n == 9, "R7", "all words after resume", n, 9);
  endtask

  task automatic t_dev_stop;
    int n; logic [15:0] c;
    run_burst(8'd2, 8'd2, 8'd1, 8'd2, 8'd3, 8'd2, 12, 0, 0, 3, n, c);
    chk(n >= 3 && n <= 4, "R13", "words before device ended burst", n, 3);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_fast();
    t_zero_counts();
    t_stream_gaps();
    t_pause();
    t_dev_stop();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R11 global watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule